// File: doc/BRIEF.md
# PCI Configuration Access Front End

This block sits between a processor's register bus and the bus side of a PCI host bridge and turns processor accesses into configuration-space cycles. Two access paths exist. The indirect path uses a configuration-address register in I/O space plus a four-byte data port. A data-port access is forwarded as one configuration cycle whose address comes from the latched register. The direct path is a memory-mapped window. In that window, the target device is named by a single set address bit, which a priority search converts into a device number.

The processor side carries one access at a time: the requester holds `cpu_req` with its attributes until `cpu_ack`. The bus side receives a registered request (`cfg_req` with address, size, direction and write data) and answers with a `cfg_done` strobe that carries the read data. When the host is big-endian, multi-byte data crossing the direct window is byte-reversed in both directions. This is selected by a parameter.

Top module: `cfg_access_front`

## Requirements
- R1: During and after synchronous active-low reset, the address register holds zero and `cfg_req` and `cpu_ack` are low.
- R2: An I/O word access (`cpu_io`=1, `cpu_size`=2) at address 0xCF8 writes or reads the 32-bit address register. `cpu_ack` rises in the cycle after the access is accepted, a read returns the last written value, and no configuration request is raised.
- R3: A byte or halfword access (`cpu_size` 0 or 1) at I/O address 0xCF8 is ignored. It is acknowledged with read data zero and leaves the address register unchanged.
- R4: An I/O access at 0xCFC..0xCFF of size 0, 1 or 2 (1, 2, 4 bytes) raises one request. Its `cfg_addr` is address-register bits 31:2 joined with port address bits 1:0. Size and direction are passed through, and write and read data are not modified.
- R5: A memory access (`cpu_io`=0) whose address bits 31:22 equal those of 0x80800000 is a direct-window access. Its `cfg_addr` bits 10:0 equal the access address bits 10:0.
- R6: In a direct-window access, `cfg_addr` bits 14:11 hold the index (0..10) of the lowest set bit among address bits 21:11, and `cfg_addr` bits 31:15 are zero.
- R7: If none of address bits 21:11 is set in a direct-window access, `cfg_addr` bits 14:11 hold 11.
- R8: With the big-endian parameter set, direct-window data is converted in both directions. A halfword becomes {16'h0, d[7:0], d[15:8]}, a word has its four bytes reversed, and a byte passes unchanged.
- R9: `cfg_req` rises in the cycle after acceptance and holds with stable address, size, direction and write data until `cfg_done`. `cpu_ack` and `cpu_rdata` appear in the same cycle as `cfg_done`, and `cfg_req` is low in the next cycle.
- R10: Any other access, including size code 3, is acknowledged in the cycle after acceptance with read data zero and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_ack` |
| cpu_io | input | 1 | 1 = I/O space, 0 = memory space |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Access address |
| cpu_size | input | 2 | 0 = byte, 1 = halfword, 2 = word, 3 = invalid |
| cpu_wdata | input | 32 | Write data, right-justified |
| cpu_ack | output | 1 | Access complete |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| cfg_req | output | 1 | Configuration cycle pending |
| cfg_we | output | 1 | Configuration write |
| cfg_addr | output | 32 | Configuration address |
| cfg_size | output | 2 | Configuration access size, same encoding |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_done | input | 1 | Bus side completes the pending cycle |
| cfg_rdata | input | 32 | Configuration read data, valid with `cfg_done` |

## Verification
Local accesses (the address register and ignored accesses) acknowledge exactly one clock after the accepting edge. The bench therefore checks read data at the falling edge that follows it. A forwarded access shows its registered request fields one clock after acceptance. Its acknowledge and read data are combinational with `cfg_done`, so they are sampled shortly after the bench raises the strobe, in that same cycle. A per-clock monitor compares `cfg_req` and `cpu_ack` with the behavioural model's expectation at every falling edge. The per-clock comparison covers zero-delay and multi-cycle completions alike.

// File: rtl/cfg_front_pkg.sv
// Package: shared encodings for the configuration access front end.
// Assumes sizes are coded 0/1/2 for 1/2/4 bytes.
package cfg_front_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOCAL = 2'd1,
        ST_BUSY  = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        PATH_NONE = 2'd0,
        PATH_ADDR = 2'd1,
        PATH_PORT = 2'd2,
        PATH_WIN  = 2'd3
    } path_e;
endpackage

// File: rtl/cfg_sel_encoder.sv
// Module: priority encoder for the direct window's device-select bits.
// Returns the index of the lowest set bit, or SEL_N when none is set.
// Assumes IDX_W can hold SEL_N.
module cfg_sel_encoder #(
    parameter int SEL_N = 11,
    parameter int IDX_W = $clog2(SEL_N + 1)
) (
    input  logic [SEL_N-1:0] sel,
    output logic [IDX_W-1:0] idx
);
    // Scan downward so the lowest set bit wins.
    always_comb begin
        idx = IDX_W'(SEL_N);
        for (int i = SEL_N - 1; i >= 0; i--) begin
            if (sel[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/cfg_lane_swap.sv
// Module: byte-lane conversion for a big-endian host.
// With SWAP_EN off, data passes unchanged. Data is right-justified.
module cfg_lane_swap
    import cfg_front_pkg::*;
#(
    parameter bit SWAP_EN = 1'b1
) (
    input  logic [1:0]  size,
    input  logic [31:0] din,
    output logic [31:0] dout
);
    generate
        if (SWAP_EN) begin : g_swap
            // Reverse the bytes that the access size covers.
            always_comb begin
                case (size_e'(size))
                    SZ_HALF: dout = {16'h0, din[7:0], din[15:8]};
                    SZ_WORD: dout = {din[7:0], din[15:8], din[23:16], din[31:24]};
                    default: dout = din;
                endcase
            end
        end else begin : g_pass
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/cfg_addr_decode.sv
// Module: classifies a processor access and forms the direct-window
// configuration address. Assumes SEL_LO + SEL_N <= WIN_LOG2.
module cfg_addr_decode
    import cfg_front_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] ADDR_PORT = 32'h0000_0CF8,
    parameter logic [31:0] DATA_PORT = 32'h0000_0CFC,
    parameter logic [31:0] WIN_BASE  = 32'h8080_0000,
    parameter int          WIN_LOG2  = 22,
    parameter int          SEL_LO    = 11,
    parameter int          SEL_N     = 11
) (
    input  logic              io,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output path_e             path,
    output logic [ADDR_W-1:0] win_addr
);
    localparam int IDX_W = $clog2(SEL_N + 1);
    localparam int PAD_W = ADDR_W - IDX_W - SEL_LO;

    logic [IDX_W-1:0] dev_idx;
    logic             hit_addr, hit_data, hit_win, size_ok;

    cfg_sel_encoder #(.SEL_N(SEL_N), .IDX_W(IDX_W)) i_enc (
        .sel (addr[SEL_LO +: SEL_N]),
        .idx (dev_idx)
    );

    // Address-range hits for each path.
    always_comb begin
        size_ok  = (size_e'(size) != SZ_BAD);
        hit_addr = io && (addr == ADDR_W'(ADDR_PORT)) && (size_e'(size) == SZ_WORD);
        hit_data = io && (addr[ADDR_W-1:2] == DATA_PORT[ADDR_W-1:2]) && size_ok;
        hit_win  = !io && (addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]) && size_ok;
    end

    // Path selection.
    always_comb begin
        if (hit_addr)      path = PATH_ADDR;
        else if (hit_data) path = PATH_PORT;
        else if (hit_win)  path = PATH_WIN;
        else               path = PATH_NONE;
    end

    assign win_addr = {{PAD_W{1'b0}}, dev_idx, addr[SEL_LO-1:0]};
endmodule

// File: rtl/cfg_access_front.sv
// Module: top of the configuration access front end. One processor access
// is served at a time; the requester holds cpu_req until cpu_ack.
// Forwarded accesses register their request and complete on cfg_done.
module cfg_access_front
    import cfg_front_pkg::*;
#(
    parameter logic [31:0] ADDR_PORT  = 32'h0000_0CF8,
    parameter logic [31:0] DATA_PORT  = 32'h0000_0CFC,
    parameter logic [31:0] WIN_BASE   = 32'h8080_0000,
    parameter int          WIN_LOG2   = 22,
    parameter int          SEL_LO     = 11,
    parameter int          SEL_N      = 11,
    parameter bit          BIG_ENDIAN = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_io,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [1:0]  cpu_size,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ack,
    output logic [31:0] cpu_rdata,
    output logic        cfg_req,
    output logic        cfg_we,
    output logic [31:0] cfg_addr,
    output logic [1:0]  cfg_size,
    output logic [31:0] cfg_wdata,
    input  logic        cfg_done,
    input  logic [31:0] cfg_rdata
);
    localparam int ADDR_W = 32;

    state_e      state;
    path_e       path;
    logic [31:0] win_addr, addr_reg, local_rdata, wr_swapped, rd_swapped;
    logic        win_q;

    cfg_addr_decode #(
        .ADDR_W(ADDR_W), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT),
        .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2), .SEL_LO(SEL_LO), .SEL_N(SEL_N)
    ) i_dec (
        .io       (cpu_io),
        .addr     (cpu_addr),
        .size     (cpu_size),
        .path     (path),
        .win_addr (win_addr)
    );

    cfg_lane_swap #(.SWAP_EN(BIG_ENDIAN)) i_wr_swap (
        .size (cpu_size),
        .din  (cpu_wdata),
        .dout (wr_swapped)
    );

    cfg_lane_swap #(.SWAP_EN(BIG_ENDIAN)) i_rd_swap (
        .size (cfg_size),
        .din  (cfg_rdata),
        .dout (rd_swapped)
    );

    // Access sequencer: accept, serve locally or forward, then return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            addr_reg    <= '0;
            local_rdata <= '0;
            cfg_req     <= 1'b0;
            cfg_we      <= 1'b0;
            cfg_addr    <= '0;
            cfg_size    <= 2'd0;
            cfg_wdata   <= '0;
            win_q       <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cpu_req) begin
                        case (path)
                            PATH_ADDR: begin
                                if (cpu_we) addr_reg <= cpu_wdata;
                                local_rdata <= cpu_we ? '0 : addr_reg;
                                state       <= ST_LOCAL;
                            end
                            PATH_PORT: begin
                                cfg_addr  <= {addr_reg[31:2], cpu_addr[1:0]};
                                cfg_wdata <= cpu_wdata;
                                cfg_we    <= cpu_we;
                                cfg_size  <= cpu_size;
                                win_q     <= 1'b0;
                                cfg_req   <= 1'b1;
                                state     <= ST_BUSY;
                            end
                            PATH_WIN: begin
                                cfg_addr  <= win_addr;
                                cfg_wdata <= wr_swapped;
                                cfg_we    <= cpu_we;
                                cfg_size  <= cpu_size;
                                win_q     <= 1'b1;
                                cfg_req   <= 1'b1;
                                state     <= ST_BUSY;
                            end
                            default: begin
                                local_rdata <= '0;
                                state       <= ST_LOCAL;
                            end
                        endcase
                    end
                end
                ST_LOCAL: state <= ST_IDLE;
                ST_BUSY: begin
                    if (cfg_done) begin
                        cfg_req <= 1'b0;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Processor response: local data one cycle after acceptance, bus data with done.
    always_comb begin
        cpu_ack   = 1'b0;
        cpu_rdata = '0;
        if (state == ST_LOCAL) begin
            cpu_ack   = 1'b1;
            cpu_rdata = local_rdata;
        end else if (state == ST_BUSY && cfg_done) begin
            cpu_ack   = 1'b1;
            cpu_rdata = win_q ? rd_swapped : cfg_rdata;
        end
    end
endmodule

// File: rtl/cfg_front_chk.sv
// Module: protocol checker for cfg_access_front, attached with bind.
module cfg_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_req,
    input logic        cpu_ack,
    input logic        cfg_req,
    input logic        cfg_done,
    input logic        cfg_we,
    input logic [1:0]  cfg_size,
    input logic [31:0] cfg_addr,
    input logic [31:0] cfg_wdata
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!cfg_req && !cpu_ack));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_done) |=> cfg_req);

    // R9
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_done) |=> ($stable(cfg_addr) && $stable(cfg_wdata)
                                    && $stable(cfg_size) && $stable(cfg_we)));

    // R9
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_done) |=> !cfg_req);

    // R9
    ack_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_done) |-> cpu_ack);

    // R10
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> cpu_req);
endmodule

bind cfg_access_front cfg_front_chk i_cfg_front_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_ack   (cpu_ack),
    .cfg_req   (cfg_req),
    .cfg_done  (cfg_done),
    .cfg_we    (cfg_we),
    .cfg_size  (cfg_size),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata)
);

// File: tb/test_cfg_access_front.sv
// Bench: behavioural model of the front end, compared at every falling edge.
module test_cfg_access_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_io = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [1:0]  cpu_size = 2'd0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        cfg_req, cfg_we;
    logic [31:0] cfg_addr, cfg_wdata;
    logic [1:0]  cfg_size;
    logic        cfg_done = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int checks = 0;
    int failures = 0;
    bit exp_req = 1'b0;
    bit exp_ack = 1'b0;

    always #4 clk = ~clk;

    cfg_access_front i_cfg_access_front (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_io(cpu_io),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
        .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_done(cfg_done),
        .cfg_rdata(cfg_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model of the direct-window address: lowest set select bit, else 11.
    function automatic logic [31:0] ref_win(input logic [31:0] a);
        for (int i = 0; i < 11; i++)
            if (a[11 + i]) return (32'(i) << 11) | (a & 32'h7FF);
        return (32'd11 << 11) | (a & 32'h7FF);
    endfunction

    // Model of the big-endian lane conversion.
    function automatic logic [31:0] ref_swap(input logic [1:0] sz, input logic [31:0] d);
        if (sz == 2'd1) return {16'h0, d[7:0], d[15:8]};
        if (sz == 2'd2) return {d[7:0], d[15:8], d[23:16], d[31:24]};
        return d;
    endfunction

    // Per-clock comparison of handshake outputs against the model (R1, R9, R10).
    always @(negedge clk) begin
        #2;
        check(cfg_req === exp_req, "R9 cfg_req per-cycle", 32'(cfg_req), 32'(exp_req));
        check(cpu_ack === exp_ack, "R10 cpu_ack per-cycle", 32'(cpu_ack), 32'(exp_ack));
    end

    task automatic drive(input bit io, input bit we, input logic [31:0] a,
                         input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_io = io; cpu_we = we;
        cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
    endtask

    // Access served inside the block: ack one cycle after acceptance.
    task automatic local_acc(input bit io, input bit we, input logic [31:0] a,
                             input logic [1:0] sz, input logic [31:0] wd,
                             input logic [31:0] exp_rd, input string tag);
        drive(io, we, a, sz, wd);
        @(negedge clk);
        exp_ack = 1'b1;
        #1;
        check(cpu_ack === 1'b1, {tag, " ack"}, 32'(cpu_ack), 32'd1);
        if (!we) check(cpu_rdata === exp_rd, {tag, " rdata"}, cpu_rdata, exp_rd);
        @(negedge clk);
        cpu_req = 1'b0;
        exp_ack = 1'b0;
    endtask

    // Access forwarded to the bus side, completed after dly idle cycles.
    task automatic cfg_acc(input bit io, input bit we, input logic [31:0] a,
                           input logic [1:0] sz, input logic [31:0] wd,
                           input logic [31:0] exp_addr, input logic [31:0] exp_wd,
                           input logic [31:0] bus_rd, input logic [31:0] exp_rd,
                           input int dly, input string tag);
        drive(io, we, a, sz, wd);
        @(negedge clk);
        exp_req = 1'b1;
        #1;
        check(cfg_addr === exp_addr, {tag, " cfg_addr"}, cfg_addr, exp_addr);
        check(cfg_size === sz, {tag, " cfg_size"}, 32'(cfg_size), 32'(sz));
        check(cfg_we === we, {tag, " cfg_we"}, 32'(cfg_we), 32'(we));
        if (we) check(cfg_wdata === exp_wd, {tag, " cfg_wdata"}, cfg_wdata, exp_wd);
        for (int k = 0; k < dly; k++) @(negedge clk);
        cfg_done = 1'b1; cfg_rdata = bus_rd; exp_ack = 1'b1;
        #1;
        check(cpu_ack === 1'b1, {tag, " ack with done"}, 32'(cpu_ack), 32'd1);
        if (!we) check(cpu_rdata === exp_rd, {tag, " rdata"}, cpu_rdata, exp_rd);
        @(negedge clk);
        cfg_done = 1'b0; cpu_req = 1'b0; exp_ack = 1'b0; exp_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] a;
        repeat (3) @(negedge clk);
        #1;
        // R1: quiet outputs during reset
        check(!cfg_req && !cpu_ack, "R1 reset outputs", {cfg_req, cpu_ack}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: address register reads zero after reset
        local_acc(1, 0, 32'hCF8, 2'd2, 0, 32'h0, "R1 addr reg reset");
        // R2: write and read back
        local_acc(1, 1, 32'hCF8, 2'd2, 32'h8000_0810, 0, "R2 addr write");
        local_acc(1, 0, 32'hCF8, 2'd2, 0, 32'h8000_0810, "R2 addr readback");
        // R3: narrow accesses to the address register are ignored
        local_acc(1, 1, 32'hCF8, 2'd0, 32'hFFFF_FFFF, 0, "R3 byte write ignored");
        local_acc(1, 0, 32'hCF8, 2'd1, 0, 32'h0, "R3 half read zero");
        local_acc(1, 0, 32'hCF8, 2'd2, 0, 32'h8000_0810, "R3 register unchanged");
        // R4: data port, no swap
        cfg_acc(1, 1, 32'hCFC, 2'd2, 32'h1122_3344, 32'h8000_0810, 32'h1122_3344,
                0, 0, 0, "R4 port word write");
        cfg_acc(1, 0, 32'hCFE, 2'd0, 0, 32'h8000_0812, 0,
                32'h0000_00A5, 32'h0000_00A5, 2, "R4 port byte read");
        cfg_acc(1, 0, 32'hCFD, 2'd1, 0, 32'h8000_0811, 0,
                32'h0000_BEEF, 32'h0000_BEEF, 1, "R4 port half read");
        // R5 R6 R8: window word write, device bit 13
        a = 32'h8080_2010;
        cfg_acc(0, 1, a, 2'd2, 32'h1122_3344, ref_win(a), ref_swap(2'd2, 32'h1122_3344),
                0, 0, 3, "R6 R8 window word write");
        // R6 R8: lowest bit wins, halfword read swapped
        a = 32'h8080_8922;
        cfg_acc(0, 0, a, 2'd1, 0, ref_win(a), 0,
                32'h0000_ABCD, ref_swap(2'd1, 32'h0000_ABCD), 0, "R6 R8 window half read");
        // R7: no select bit
        a = 32'h8080_07FC;
        cfg_acc(0, 0, a, 2'd2, 0, ref_win(a), 0,
                32'hDEAD_BEEF, ref_swap(2'd2, 32'hDEAD_BEEF), 1, "R7 window no select");
        // R6: highest select bit only
        a = 32'h80A0_0004;
        cfg_acc(0, 1, a, 2'd1, 32'h0000_1234, ref_win(a), ref_swap(2'd1, 32'h0000_1234),
                0, 0, 0, "R6 window bit21");
        // R8: byte never swapped, R5 offset pass-through
        a = 32'h80BF_F8FF;
        cfg_acc(0, 0, a, 2'd0, 0, ref_win(a), 0,
                32'h0000_005A, 32'h0000_005A, 0, "R5 R8 window byte");
        // R10: ignored accesses
        local_acc(0, 0, 32'h8000_0000, 2'd2, 0, 32'h0, "R10 outside memory");
        local_acc(1, 0, 32'h8080_0000, 2'd2, 0, 32'h0, "R10 io at window");
        local_acc(1, 0, 32'hCFC, 2'd3, 0, 32'h0, "R10 bad size");
        local_acc(0, 0, 32'h0000_0CF8, 2'd2, 0, 32'h0, "R10 memory at port");
        local_acc(1, 0, 32'hCF8, 2'd2, 0, 32'h8000_0810, "R2 final readback");
        repeat (2) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule